// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing Nibble-Lane FIFO

This block moves a group of parallel data lanes from a write clock domain into an unrelated read clock domain through eight entries of storage. Each write stores ten byte-wide lanes. A configuration input picks one of two lane layouts. In the wide-nibble layout, each entry leaves as twelve 4-bit lanes in a single read. In the serialized layout, each entry leaves as ten 4-bit lanes over two reads, so one write is drained by two reads.

The write side reports full and almost-full in its own clock domain. The read side reports empty and almost-empty in its own clock domain. Read data is show-ahead: the head entry is visible on the read port while empty is low, and a read strobe consumes it. Pointers cross between the domains as Gray codes through two-flop synchronizers. Because of this, a flag that rises in one domain reflects the other domain's activity only after a few cycles of delay.

Top module: `olf_top`

## Requirements
- R1: The FIFO accepts exactly eight writes while no reads take place. Full is low after seven of them and high after the eighth.
- R2: Almost-full is high, in the write clock domain, whenever the number of free entries is at most AF_LEVEL. AF_LEVEL is 1 or 2, with a default of 2. Full never appears without almost-full.
- R3: Empty is high whenever no entry is held. Almost-empty is high whenever the number of held entries is at most AE_LEVEL. AE_LEVEL is 1 or 2, with a default of 1. Both flags belong to the read clock domain. In the serialized layout, an entry that is half read still counts as held.
- R4: A write strobe while full is high is ignored. The pointer is unchanged, and the offered data never appears at the read port.
- R5: A read strobe while empty is high is ignored. The next written entry is the next one read.
- R6: In the wide-nibble layout (cfg_narrow = 0), rd_data lane i bits [3:0] carry wr_data lane i bits [3:0] for lanes 0 through 9.
- R7: In the wide-nibble layout, rd_data lane 5 bits [7:4] carry wr_data lane 5 bits [7:4], and rd_data lane 6 bits [7:4] carry wr_data lane 6 bits [7:4]. These are the two extra lanes. The upper nibbles of all other input lanes are ignored.
- R8: In the wide-nibble layout, bits [7:4] of rd_data lanes 0, 1, 2, 3, 4, 7, 8 and 9 are zero.
- R9: In the serialized layout (cfg_narrow = 1), the first read of an entry shows bits [3:0] of each input lane on rd_data lane bits [3:0]. The second read shows bits [7:4] in the same place. Bits [7:4] of every output lane are zero.
- R10: In the serialized layout, an entry is released only by its second read. After the first read, the same entry is still held.
- R11: The layout is sampled only while reset is applied. A change of cfg_narrow after reset has no effect until the next reset.
- R12: Reset clears both pointers, sets empty and almost-empty, and clears full and almost-full.
- R13: Entries leave in the order they were written. The Gray pointer crossing the domains changes at most one bit per clock.
- R14: Writes and reads may happen at the same time, in their own domains, without loss, duplication or reordering of entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low, asynchronous assert |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 10x8 | Ten byte-wide input lanes |
| full | output | 1 | No free entry (write domain) |
| almost_full | output | 1 | Free entries at most AF_LEVEL (write domain) |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low, asynchronous assert |
| rd_en | input | 1 | Read strobe, consumes the shown beat |
| rd_data | output | 10x8 | Output lanes, layout set by cfg_narrow |
| empty | output | 1 | No entry held (read domain) |
| almost_empty | output | 1 | Held entries at most AE_LEVEL (read domain) |
| cfg_narrow | input | 1 | Layout: 0 wide-nibble, 1 serialized; sampled during reset |

## Verification
A push and a pop can land in the same stretch of time in their two domains. A pop can also arrive while a late pointer update is still crossing, which is when a stale flag could let an entry be lost or read twice. The bench preloads three entries. It then runs a writer and a reader concurrently on two phase-shifted clocks: the writer pushes six more entries while the reader drains all nine, popping whenever empty is low. Each popped value is compared in order against the expected sequence, and the FIFO must be empty at the end.

// File: rtl/olf_pkg.sv
package olf_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic {
    LAYOUT_WIDE   = 1'b0,
    LAYOUT_SERIAL = 1'b1
  } layout_e;

endpackage

// File: rtl/olf_rst_sync.sv
module olf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q = chain_q[STAGES-1];

endmodule

// File: rtl/olf_gray_sync.sv
module olf_gray_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] gray_out
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign gray_out = sync_q;

endmodule

// File: rtl/olf_wr_ctl.sv
module olf_wr_ctl #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned AF_LEVEL = 2
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rd_gray_s,
  output logic [ADDR_W:0]   wr_bin,
  output logic [ADDR_W:0]   wr_gray,
  output logic              wr_fire,
  output logic              full,
  output logic              almost_full
);

  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PW-1:0] bin_q, bin_d;
  logic [PW-1:0] gray_q, gray_d;
  logic [PW-1:0] rd_bin_s;
  logic [PW-1:0] used;
  logic [PW-1:0] full_pat;

  always_comb begin
    rd_bin_s[PW-1] = rd_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      rd_bin_s[i] = rd_bin_s[i+1] ^ rd_gray_s[i];
    end
  end

  always_comb begin
    full_pat           = rd_gray_s;
    full_pat[PW-1]     = ~rd_gray_s[PW-1];
    full_pat[PW-2]     = ~rd_gray_s[PW-2];
    full               = (gray_q == full_pat);
    used               = bin_q - rd_bin_s;
    almost_full        = (used >= PW'(DEPTH - AF_LEVEL));
    wr_fire            = wr_en && !full;
    bin_d              = wr_fire ? bin_q + PW'(1) : bin_q;
    gray_d             = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (wr_fire) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign wr_bin  = bin_q;
  assign wr_gray = gray_q;

endmodule

// File: rtl/olf_rd_ctl.sv
module olf_rd_ctl
  import olf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned AE_LEVEL = 1
) (
  input  logic            clk,
  input  logic            rst_q,
  input  logic            rd_en,
  input  logic            layout_in,
  input  logic [ADDR_W:0] wr_gray_s,
  output logic [ADDR_W:0] rd_bin,
  output logic [ADDR_W:0] rd_gray,
  output logic            beat,
  output layout_e         layout,
  output logic            empty,
  output logic            almost_empty
);

  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] bin_q, bin_d;
  logic [PW-1:0] gray_q, gray_d;
  logic [PW-1:0] wr_bin_s;
  logic [PW-1:0] held;
  logic          beat_q, beat_d;
  logic          pop_ok, release_ok;
  layout_e       layout_q;

  always_ff @(posedge clk) begin
    if (!rst_q) begin
      layout_q <= layout_e'(layout_in);
    end
  end

  always_comb begin
    wr_bin_s[PW-1] = wr_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
    end
  end

  always_comb begin
    empty        = (gray_q == wr_gray_s);
    held         = wr_bin_s - bin_q;
    almost_empty = (held <= PW'(AE_LEVEL));
    pop_ok       = rd_en && !empty;
    release_ok   = pop_ok && ((layout_q == LAYOUT_WIDE) || beat_q);
    beat_d       = (pop_ok && (layout_q == LAYOUT_SERIAL)) ? ~beat_q : beat_q;
    bin_d        = release_ok ? bin_q + PW'(1) : bin_q;
    gray_d       = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bin_q  <= '0;
      gray_q <= '0;
      beat_q <= 1'b0;
    end else if (pop_ok) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      beat_q <= beat_d;
    end
  end

  assign rd_bin  = bin_q;
  assign rd_gray = gray_q;
  assign beat    = beat_q;
  assign layout  = layout_q;

endmodule

// File: rtl/olf_lane_out.sv
module olf_lane_out
  import olf_pkg::*;
#(
  parameter int unsigned NUM_LANES = 10,
  parameter int unsigned XLANE_A   = 5,
  parameter int unsigned XLANE_B   = 6
) (
  input  logic [NUM_LANES-1:0][BYTE_W-1:0] entry,
  input  layout_e                          layout,
  input  logic                             beat,
  output logic [NUM_LANES-1:0][BYTE_W-1:0] lanes
);

  logic pick_hi;

  assign pick_hi = (layout == LAYOUT_SERIAL) && beat;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lanes[g][NIB_W-1:0] = pick_hi ? entry[g][BYTE_W-1:NIB_W]
                                         : entry[g][NIB_W-1:0];
    if ((g == XLANE_A) || (g == XLANE_B)) begin : g_extra
      assign lanes[g][BYTE_W-1:NIB_W] = (layout == LAYOUT_WIDE) ?
                                        entry[g][BYTE_W-1:NIB_W] : '0;
    end else begin : g_plain
      assign lanes[g][BYTE_W-1:NIB_W] = '0;
    end
  end

endmodule

// File: rtl/olf_top.sv
module olf_top
  import olf_pkg::*;
#(
  parameter int unsigned NUM_LANES = 10,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned AE_LEVEL  = 1,
  parameter int unsigned AF_LEVEL  = 2,
  parameter int unsigned XLANE_A   = 5,
  parameter int unsigned XLANE_B   = 6
) (
  input  logic                             wr_clk,
  input  logic                             wr_rst_n,
  input  logic                             wr_en,
  input  logic [NUM_LANES-1:0][BYTE_W-1:0] wr_data,
  output logic                             full,
  output logic                             almost_full,
  input  logic                             rd_clk,
  input  logic                             rd_rst_n,
  input  logic                             rd_en,
  output logic [NUM_LANES-1:0][BYTE_W-1:0] rd_data,
  output logic                             empty,
  output logic                             almost_empty,
  input  logic                             cfg_narrow
);

  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic          wr_rst_q, rd_rst_q;
  logic [PW-1:0] wr_bin, wr_gray, wr_gray_s;
  logic [PW-1:0] rd_bin, rd_gray, rd_gray_s;
  logic          wr_fire;
  logic          rd_beat;
  layout_e       rd_layout;

  logic [NUM_LANES-1:0][BYTE_W-1:0] store_q [DEPTH];
  logic [NUM_LANES-1:0][BYTE_W-1:0] head;

  olf_rst_sync #(.STAGES(2)) u_wrst (
    .clk(wr_clk), .arst_n(wr_rst_n), .rst_q(wr_rst_q)
  );

  olf_rst_sync #(.STAGES(2)) u_rrst (
    .clk(rd_clk), .arst_n(rd_rst_n), .rst_q(rd_rst_q)
  );

  olf_gray_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_q(wr_rst_q), .gray_in(rd_gray), .gray_out(rd_gray_s)
  );

  olf_gray_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_q(rd_rst_q), .gray_in(wr_gray), .gray_out(wr_gray_s)
  );

  olf_wr_ctl #(.ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wctl (
    .clk(wr_clk), .rst_q(wr_rst_q), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
    .wr_bin(wr_bin), .wr_gray(wr_gray), .wr_fire(wr_fire),
    .full(full), .almost_full(almost_full)
  );

  olf_rd_ctl #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rctl (
    .clk(rd_clk), .rst_q(rd_rst_q), .rd_en(rd_en), .layout_in(cfg_narrow),
    .wr_gray_s(wr_gray_s), .rd_bin(rd_bin), .rd_gray(rd_gray),
    .beat(rd_beat), .layout(rd_layout),
    .empty(empty), .almost_empty(almost_empty)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_fire) begin
      store_q[wr_bin[ADDR_W-1:0]] <= wr_data;
    end
  end

  assign head = store_q[rd_bin[ADDR_W-1:0]];

  olf_lane_out #(
    .NUM_LANES(NUM_LANES), .XLANE_A(XLANE_A), .XLANE_B(XLANE_B)
  ) u_lanes (
    .entry(head), .layout(rd_layout), .beat(rd_beat), .lanes(rd_data)
  );

endmodule

// File: rtl/olf_chk.sv
module olf_chk
  import olf_pkg::*;
#(
  parameter int unsigned NUM_LANES = 10,
  parameter int unsigned PW        = 4,
  parameter int unsigned XLANE_A   = 5,
  parameter int unsigned XLANE_B   = 6
) (
  input logic                             wr_clk,
  input logic                             wr_rst_q,
  input logic                             wr_en,
  input logic                             full,
  input logic                             almost_full,
  input logic [PW-1:0]                    wr_bin,
  input logic [PW-1:0]                    wr_gray,
  input logic                             rd_clk,
  input logic                             rd_rst_q,
  input logic                             rd_en,
  input logic                             empty,
  input logic                             almost_empty,
  input logic [PW-1:0]                    rd_bin,
  input logic                             rd_beat,
  input layout_e                          rd_layout,
  input logic [NUM_LANES-1:0][BYTE_W-1:0] rd_data
);

  logic [NIB_W-1:0] any_upper;
  logic [NIB_W-1:0] spare_upper;

  always_comb begin
    any_upper   = '0;
    spare_upper = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      any_upper = any_upper | rd_data[i][BYTE_W-1:NIB_W];
      if ((i != XLANE_A) && (i != XLANE_B)) begin
        spare_upper = spare_upper | rd_data[i][BYTE_W-1:NIB_W];
      end
    end
  end

  assert_write_ignored_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_q)
    (wr_en && full) |=> $stable(wr_bin));

  assert_read_ignored_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    (rd_en && empty) |=> ($stable(rd_bin) && $stable(rd_beat)));

  assert_full_has_afull_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_q)
    full |-> almost_full);

  assert_empty_has_aempty_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    empty |-> almost_empty);

  assert_gray_one_step_R13: assert property (@(posedge wr_clk) disable iff (!wr_rst_q)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  assert_serial_upper_zero_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    (rd_layout == LAYOUT_SERIAL) |-> (any_upper == '0));

  assert_wide_spare_zero_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    (rd_layout == LAYOUT_WIDE) |-> (spare_upper == '0));

  assert_first_beat_holds_R10: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    ((rd_layout == LAYOUT_SERIAL) && rd_en && !empty && !rd_beat)
      |=> ($stable(rd_bin) && rd_beat && !empty));

endmodule

bind olf_top olf_chk #(
  .NUM_LANES(NUM_LANES), .PW(PW), .XLANE_A(XLANE_A), .XLANE_B(XLANE_B)
) u_chk (
  .wr_clk(wr_clk), .wr_rst_q(wr_rst_q), .wr_en(wr_en), .full(full),
  .almost_full(almost_full), .wr_bin(wr_bin), .wr_gray(wr_gray),
  .rd_clk(rd_clk), .rd_rst_q(rd_rst_q), .rd_en(rd_en), .empty(empty),
  .almost_empty(almost_empty), .rd_bin(rd_bin), .rd_beat(rd_beat),
  .rd_layout(rd_layout), .rd_data(rd_data)
);

// File: tb/sim_olf_top.sv
module sim_olf_top;

  logic             wr_clk = 1'b0;
  logic             rd_clk = 1'b0;
  logic             wr_rst_n = 1'b0;
  logic             rd_rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic             cfg_narrow = 1'b0;
  logic [9:0][7:0]  wr_data = '0;
  logic [9:0][7:0]  rd_data;
  logic             full, almost_full, empty, almost_empty;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [79:0] WIDE_MASK = 80'h0F0F_0FFF_FF0F_0F0F_0F0F;

  // {input entry, expected wide-layout output}
  localparam logic [159:0] VEC [4] = '{
    {80'hFFFF_FFFF_FFFF_FFFF_FFFF, 80'h0F0F_0FFF_FF0F_0F0F_0F0F},
    {80'h1234_5678_9ABC_DEF0_1357, 80'h0204_0678_9A0C_0E00_0307},
    {80'hA5A5_A5A5_A5A5_A5A5_A5A5, 80'h0505_05A5_A505_0505_0505},
    {80'h5A00_C3FF_0011_2233_4455, 80'h0A00_03FF_0001_0203_0405}
  };

  always #4 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #4 rd_clk = ~rd_clk;
  end

  olf_top u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .almost_full(almost_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty), .cfg_narrow(cfg_narrow)
  );

  function automatic logic [79:0] serial_exp(input logic [79:0] d, input bit hi);
    logic [79:0] r = '0;
    for (int i = 0; i < 10; i++) begin
      r[8*i +: 4] = hi ? d[8*i+4 +: 4] : d[8*i +: 4];
    end
    return r;
  endfunction

  function automatic logic [79:0] fill_pat(input int k);
    return {10{4'(k), ~4'(k)}};
  endfunction

  function automatic logic [79:0] mix_pat(input int k);
    return {5{8'h3C ^ 8'(k), 8'hC3 + 8'(k)}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic push(input logic [79:0] d);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge wr_clk);
    wr_en   = 1'b0;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset(input bit narrow);
    wr_rst_n   = 1'b0;
    rd_rst_n   = 1'b0;
    cfg_narrow = narrow;
    repeat (4) @(negedge wr_clk);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    settle();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 80'h0, 80'h1);
      report();
    end
  end

  initial begin
    do_reset(1'b0);

    // R12 reset state
    check(empty && almost_empty && !full && !almost_full, "R12",
          80'({empty, almost_empty, full, almost_full}), 80'hC);

    // R6 R7 R8 R13: table of vectors in the wide layout
    for (int v = 0; v < 4; v++) begin
      push(VEC[v][159:80]);
      settle();
      check(rd_data == VEC[v][79:0], "R6/R7/R8", rd_data, VEC[v][79:0]);
      pop();
    end
    settle();
    check(empty, "R3 drained", 80'(empty), 80'h1);

    // R1 R2 R3: fill eight entries
    for (int k = 0; k < 8; k++) begin
      push(fill_pat(k));
      settle();
      if (k == 0) check(!empty && almost_empty, "R3 one held", 80'(almost_empty), 80'h1);
      if (k == 1) check(!almost_empty, "R3 two held", 80'(almost_empty), 80'h0);
      if (k == 4) check(!almost_full, "R2 three free", 80'(almost_full), 80'h0);
      if (k == 5) check(almost_full && !full, "R2 two free", 80'({almost_full, full}), 80'h2);
      if (k == 6) check(!full, "R1 seven held", 80'(full), 80'h0);
      if (k == 7) check(full, "R1 eight held", 80'(full), 80'h1);
    end

    // R4: write while full is dropped
    push(80'hDEAD_BEEF_DEAD_BEEF_DEAD);
    settle();
    check(full, "R4 still full", 80'(full), 80'h1);
    for (int k = 0; k < 8; k++) begin
      check(rd_data == (fill_pat(k) & WIDE_MASK), "R4/R13 order",
            rd_data, fill_pat(k) & WIDE_MASK);
      pop();
      settle();
    end
    check(empty, "R4 extra not stored", 80'(empty), 80'h1);

    // R5: read while empty is ignored
    pop();
    settle();
    push(VEC[1][159:80]);
    settle();
    check(rd_data == VEC[1][79:0], "R5", rd_data, VEC[1][79:0]);
    pop();
    settle();
    check(empty, "R5 single pop releases", 80'(empty), 80'h1);

    // R11: layout change without reset has no effect
    cfg_narrow = 1'b1;
    push(VEC[0][159:80]);
    settle();
    check(rd_data == VEC[0][79:0], "R11 layout held", rd_data, VEC[0][79:0]);
    pop();
    settle();
    check(empty, "R11 one read releases", 80'(empty), 80'h1);
    cfg_narrow = 1'b0;

    // R14: concurrent push and pop
    for (int k = 0; k < 3; k++) push(mix_pat(k));
    settle();
    fork
      begin
        for (int k = 3; k < 9; k++) begin
          @(negedge wr_clk);
          while (full) @(negedge wr_clk);
          wr_en   = 1'b1;
          wr_data = mix_pat(k);
          @(negedge wr_clk);
          wr_en   = 1'b0;
        end
      end
      begin
        int got = 0;
        while (got < 9) begin
          @(negedge rd_clk);
          if (!empty) begin
            check(rd_data == (mix_pat(got) & WIDE_MASK), "R14",
                  rd_data, mix_pat(got) & WIDE_MASK);
            rd_en = 1'b1;
            got++;
          end else begin
            rd_en = 1'b0;
          end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
      end
    join
    settle();
    check(empty, "R14 drained", 80'(empty), 80'h1);

    // R9 R10: serialized layout
    do_reset(1'b1);
    check(empty && !full, "R12 second reset", 80'({empty, full}), 80'h2);
    push(VEC[1][159:80]);
    settle();
    check(rd_data == serial_exp(VEC[1][159:80], 1'b0), "R9 first beat",
          rd_data, serial_exp(VEC[1][159:80], 1'b0));
    pop();
    settle();
    check(!empty, "R10 entry held after first beat", 80'(empty), 80'h0);
    check(rd_data == serial_exp(VEC[1][159:80], 1'b1), "R9 second beat",
          rd_data, serial_exp(VEC[1][159:80], 1'b1));
    pop();
    settle();
    check(empty, "R10 released after second beat", 80'(empty), 80'h1);

    done = 1'b1;
    report();
  end

endmodule